// File: doc/BRIEF.md
# Closed-Caption Data Capture Registers

This block sits behind a caption bit slicer for the text line of a 525-line picture. Each time the slicer finishes a line it pulses a capture strobe together with the two received bytes and a field identifier. The block keeps one pair of byte registers for each field. When it stores a byte it overwrites bit 7 with the outcome of a parity check, so the host receives seven data bits and a parity-good flag in each byte.

A status register holds a valid flag and a ready flag for each field, plus one host-writable bit that chooses which field's pair the two data addresses return. A field's valid flag stays set while captures keep arriving. It drops after a parameterised number of frame pulses pass with no capture for that field. The ready flag supports polling. A capture sets it. It drops when the host reads the second data byte of that field, and it stays low until the next capture for that field.

The host port is a plain register port. It has one address, a read strobe, a write strobe and write data for the field-select bit, and registered read data.

Top module: `cc_capture_regs`

## Requirements
- R1: A capture strobe with `cap_field`=0 (field 1) or 1 (field 2) stores `cap_byte0` and `cap_byte1` in that field's pair. Bits 6:0 of each stored byte equal the received bits 6:0. The other field's pair is unchanged.
- R2: Bit 7 of each stored byte is 1 exactly when the 8 received bits hold an odd number of ones (odd parity correct), and 0 otherwise.
- R3: The status register sits at address 0x1C. Bit 0 is the field-1 valid flag, bit 1 the field-1 ready flag, bit 2 the field-2 valid flag, bit 3 the field-2 ready flag and bit 7 the field select. Bits 6:4 read 0.
- R4: A capture sets the valid flag and the ready flag of its own field on the next clock edge and does not alter the other field's flags.
- R5: A read of address 0x1B clears the ready flag of the selected field only. A read of address 0x1A, or of the status register, clears no flag.
- R6: When a capture for a field and a clearing read of that same field happen in the same cycle, the ready flag of that field ends set.
- R7: A field's valid flag clears on the TIMEOUT_FRAMES-th frame pulse after that field's last capture, if no capture for that field arrives in between. A capture in the same cycle as a frame pulse keeps the flag set and restarts the count.
- R8: A write to 0x1C loads bit 7 of the write data into the field select. Select 0 maps addresses 0x1A and 0x1B to field-1 bytes 0 and 1. Select 1 maps them to the field-2 bytes. The write does not change the valid or ready flags.
- R9: After reset all stored bytes, all flags, the field select and the read data are 0.
- R10: Read data appears on the clock edge that samples the read strobe and holds while no read occurs. An address outside 0x1A to 0x1C reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_valid | input | 1 | One-cycle strobe: a caption line has been decoded |
| cap_field | input | 1 | Field of the capture, 0 = field 1, 1 = field 2 |
| cap_byte0 | input | 8 | First received byte, including its parity bit |
| cap_byte1 | input | 8 | Second received byte, including its parity bit |
| frame_tick | input | 1 | One-cycle pulse once per frame |
| reg_addr | input | 8 | Register address for read or write |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (only 0x1C is writable) |
| wr_data | input | 8 | Write data, bit 7 is the field select |
| rd_data | output | 8 | Registered read data |

## Verification
The hardest situation to reach is a capture and a clearing read of the same field landing on one clock edge. The collision only counts when the field select already points at the capturing field. The bench first writes the select bit. It then drives the capture strobe and the read strobe for 0x1B from the same negative edge, and reads the status register afterwards. The timeout path also needs care: the bench issues exactly one frame pulse fewer than the limit and expects the flag still set, then sends one more pulse. It then sends a pulse together with a capture to show that the count restarts.

// File: rtl/cc_capture_pkg.sv
package cc_capture_pkg;

    localparam logic [7:0] ADDR_BYTE0  = 8'h1A;
    localparam logic [7:0] ADDR_BYTE1  = 8'h1B;
    localparam logic [7:0] ADDR_STATUS = 8'h1C;
    localparam int         NUM_FIELDS  = 2;

    // Replace bit 7 by the odd-parity result over all eight received bits.
    function automatic logic [7:0] fold_parity(input logic [7:0] raw);
        return {^raw, raw[6:0]};
    endfunction

endpackage

// File: rtl/cc_field_slot.sv
module cc_field_slot #(
    parameter int TIMEOUT_FRAMES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_i,
    input  logic [7:0] b0_i,
    input  logic [7:0] b1_i,
    input  logic       tick_i,
    input  logic       clr_rdy_i,
    output logic [7:0] b0_o,
    output logic [7:0] b1_o,
    output logic       valid_o,
    output logic       ready_o
);
    import cc_capture_pkg::*;

    localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_FRAMES - 1);

    typedef struct packed {
        logic [7:0]       b0;
        logic [7:0]       b1;
        logic             valid;
        logic             ready;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_rdy_i) begin
            st_d.ready = 1'b0;
        end
        if (cap_i) begin
            st_d.b0    = fold_parity(b0_i);
            st_d.b1    = fold_parity(b1_i);
            st_d.valid = 1'b1;
            st_d.ready = 1'b1;
            st_d.cnt   = '0;
        end else if (tick_i && st_q.valid) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.valid = 1'b0;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign b0_o    = st_q.b0;
    assign b1_o    = st_q.b1;
    assign valid_o = st_q.valid;
    assign ready_o = st_q.ready;

    // R4: ready only rises as a result of a capture
    assert_ready_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ready) |-> $past(cap_i));
    // R5 / R6: ready only falls on a clearing read without a capture
    assert_ready_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.ready) |-> ($past(clr_rdy_i) && !$past(cap_i)));
    // R7: valid only falls on a frame pulse
    assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.valid) |-> ($past(tick_i) && !$past(cap_i)));
    // R7: frame counter stays inside its window
    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(TIMEOUT_FRAMES));
    // R1: bytes only change on a capture
    assert_bytes_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> ($stable(st_q.b0) && $stable(st_q.b1)));

endmodule

// File: rtl/cc_capture_regs.sv
module cc_capture_regs #(
    parameter int TIMEOUT_FRAMES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_valid,
    input  logic       cap_field,
    input  logic [7:0] cap_byte0,
    input  logic [7:0] cap_byte1,
    input  logic       frame_tick,
    input  logic [7:0] reg_addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data
);
    import cc_capture_pkg::*;

    typedef struct packed {
        logic       sel;
        logic [7:0] rdat;
    } host_t;

    host_t h_d, h_q;

    logic [7:0] b0_w [NUM_FIELDS];
    logic [7:0] b1_w [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] valid_w, ready_w, clr_w;
    logic [7:0] status_w;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign clr_w[f] = rd_en && (reg_addr == ADDR_BYTE1) && (h_q.sel == f[0]);
        cc_field_slot #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_i    (cap_valid && (cap_field == f[0])),
            .b0_i     (cap_byte0),
            .b1_i     (cap_byte1),
            .tick_i   (frame_tick),
            .clr_rdy_i(clr_w[f]),
            .b0_o     (b0_w[f]),
            .b1_o     (b1_w[f]),
            .valid_o  (valid_w[f]),
            .ready_o  (ready_w[f])
        );
    end

    assign status_w = {h_q.sel, 3'b000, ready_w[1], valid_w[1], ready_w[0], valid_w[0]};

    always_comb begin
        h_d = h_q;
        if (wr_en && reg_addr == ADDR_STATUS) begin
            h_d.sel = wr_data[7];
        end
        if (rd_en) begin
            unique case (reg_addr)
                ADDR_BYTE0:  h_d.rdat = h_q.sel ? b0_w[1] : b0_w[0];
                ADDR_BYTE1:  h_d.rdat = h_q.sel ? b1_w[1] : b1_w[0];
                ADDR_STATUS: h_d.rdat = status_w;
                default:     h_d.rdat = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign rd_data = h_q.rdat;

    // R10: read data holds when no read is issued
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    // R5: at most one field is cleared by a read
    assert_one_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_w));
    // R8: select only changes on a status write
    assert_sel_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == ADDR_STATUS) |=> $stable(h_q.sel));

endmodule

// File: tb/cc_capture_regs_tb_top.sv
module cc_capture_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TO_FRAMES  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_valid = 1'b0, cap_field = 1'b0;
    logic [7:0] cap_byte0 = '0, cap_byte1 = '0;
    logic       frame_tick = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cc_capture_regs #(.TIMEOUT_FRAMES(TO_FRAMES)) dut_i (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_field(cap_field),
        .cap_byte0(cap_byte0), .cap_byte1(cap_byte1), .frame_tick(frame_tick),
        .reg_addr(reg_addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] expect_byte(input logic [7:0] raw);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += raw[i];
        return {((ones % 2) == 1) ? 1'b1 : 1'b0, raw[6:0]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic capture(input logic fld, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        cap_valid = 1'b1; cap_field = fld; cap_byte0 = a; cap_byte1 = b;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] addr, output logic [7:0] val);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = addr;
        @(negedge clk);
        rd_en = 1'b0;
        val = rd_data;
    endtask

    task automatic write_sel(input logic s);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 8'h1C; wr_data = {s, 7'h7F};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); frame_tick = 1'b1;
            @(negedge clk); frame_tick = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 rd_data after reset", rd_data, 8'h00);
        rst_n = 1'b1;
        read_reg(8'h1C, v); check("R9 status after reset", v, 8'h00);
        read_reg(8'h1A, v); check("R9 byte0 after reset", v, 8'h00);

        // R1 R2: full sweep of byte values into field 1
        for (int k = 0; k < 256; k++) begin
            capture(1'b0, 8'(k), 8'(~k));
            read_reg(8'h1A, v); check("R2 field1 byte0", v, expect_byte(8'(k)));
            read_reg(8'h1B, v); check("R1 field1 byte1", v, expect_byte(8'(~k)));
        end

        // R4 R3: fresh field-1 capture
        capture(1'b0, 8'h15, 8'h80);
        read_reg(8'h1C, v); check("R4 status after f1 capture", v, 8'h03);
        read_reg(8'h1A, v); check("R5 status read / byte0 read", v, expect_byte(8'h15));
        read_reg(8'h1C, v); check("R5 byte0 read keeps ready", v, 8'h03);
        read_reg(8'h1B, v); check("R1 f1 byte1", v, expect_byte(8'h80));
        read_reg(8'h1C, v); check("R5 byte1 read clears f1 ready", v, 8'h01);

        // R4: field-2 capture leaves field 1 flags alone
        capture(1'b1, 8'h41, 8'h42);
        read_reg(8'h1C, v); check("R4 status after f2 capture", v, 8'h0D);
        read_reg(8'h1B, v); check("R1 sel0 still field1", v, expect_byte(8'h80));
        read_reg(8'h1C, v); check("R5 sel0 read leaves f2 ready", v, 8'h0D);

        // R8: select field 2
        write_sel(1'b1);
        read_reg(8'h1C, v); check("R8 select write status", v, 8'h8D);
        read_reg(8'h1A, v); check("R8 field2 byte0", v, expect_byte(8'h41));
        read_reg(8'h1B, v); check("R8 field2 byte1", v, expect_byte(8'h42));
        read_reg(8'h1C, v); check("R5 f2 ready cleared", v, 8'h85);

        // R6: capture and clearing read in one cycle
        @(negedge clk);
        cap_valid = 1'b1; cap_field = 1'b1; cap_byte0 = 8'h07; cap_byte1 = 8'h70;
        rd_en = 1'b1; reg_addr = 8'h1B;
        @(negedge clk);
        cap_valid = 1'b0; rd_en = 1'b0;
        check("R6 read data is pre-capture byte", rd_data, expect_byte(8'h42));
        read_reg(8'h1C, v); check("R6 capture wins over clear", v, 8'h8D);

        // R10: hold and unmapped
        repeat (4) @(negedge clk);
        check("R10 read data holds", rd_data, 8'h8D);
        read_reg(8'h00, v); check("R10 unmapped reads zero", v, 8'h00);
        read_reg(8'h1D, v); check("R10 unmapped 1D reads zero", v, 8'h00);

        // R7: timeout on frame pulses
        write_sel(1'b0);
        capture(1'b0, 8'h01, 8'h02);
        capture(1'b1, 8'h03, 8'h04);
        ticks(TO_FRAMES - 1);
        read_reg(8'h1C, v); check("R7 valid kept before limit", v, 8'h0F);
        // pulse together with a field-1 capture: field 1 restarts, field 2 expires
        @(negedge clk);
        frame_tick = 1'b1; cap_valid = 1'b1; cap_field = 1'b0;
        @(negedge clk);
        frame_tick = 1'b0; cap_valid = 1'b0;
        read_reg(8'h1C, v); check("R7 f2 expires, f1 restarted", v, 8'h0B);
        ticks(TO_FRAMES - 1);
        read_reg(8'h1C, v); check("R7 f1 kept after restart", v, 8'h0B);
        ticks(1);
        read_reg(8'h1C, v); check("R7 f1 expires", v, 8'h0A);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule